// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the clock master of a stereo audio serial link. It divides its system clock into a bit clock and a word clock. The bit clock makes 64 cycles in each word-clock period, and the word clock runs at the sample rate. Each frame, the block sends one left and one right two's-complement sample on a single data line.

Samples arrive as a pair through a valid/ready handshake. The block offers the handshake once per frame, just before the frame begins. If no pair is offered then, the previous pair is sent again.

A 2-bit format code selects the framing. Codes 0 to 2 use MSB-justified framing: word clock high marks the left channel. Code 3 uses I2S framing: word clock low marks the left channel, and the MSB is delayed by one bit. The format code is read only at the frame boundary.

Top module: `audio_ser_tx`

## Requirements
- R1: The bit clock `sclk` has a period of exactly `DIV` system clocks, high for `DIV/2` and low for `DIV/2`, and one word-clock period spans `2*HALF_SLOTS` (64 by default) bit-clock periods.
- R2: While `rst` is high, `sclk`, `lrck`, `sdata` and `in_ready` are all low.
- R3: `lrck` and `sdata` change only on the system clock edge at which `sclk` falls, so they are stable while `sclk` is high and can be latched on its rising edge.
- R4: For format codes 0, 1 and 2, `lrck` is 1 for the first 32 slots of the frame (left) and 0 for the last 32 (right). In each half, slots 0 to 19 carry the 20-bit sample MSB first, and slots 20 to 31 are driven 0.
- R5: For format code 3, `lrck` is 0 for the first 32 slots (left) and 1 for the last 32 (right). In each half, slot 0 is 0, slots 1 to 20 carry the sample MSB first, and slots 21 to 31 are 0.
- R6: `in_ready` is high for exactly one system clock per frame, in the cycle just before slot 0 begins. A pair is taken only when `in_valid` is high in that cycle, and it is sent in the frame that follows.
- R7: If `in_valid` is low in the `in_ready` cycle, the frame resends the previously accepted pair, in the newly selected format.
- R8: `fmt_sel` is sampled only in the `in_ready` cycle. Changes at any other time do not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing code: 0..2 MSB-justified, 3 I2S |
| in_valid | input | 1 | Stereo pair offered |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_ready | output | 1 | Pair taken at this edge if `in_valid` is high |
| sclk | output | 1 | Bit clock, 64 per frame |
| lrck | output | 1 | Word clock, one period per frame |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with `DIV=4`, which keeps a frame at 256 system clocks while `SAMPLE_W=20` and `HALF_SLOTS=32` keep the real 64-slot frame. Nine back-to-back frames therefore fit in a short run. These frames mix all four format codes, include two repeats with no valid input, and use extreme sample values. Between handshakes, the bench scrambles the format and the samples and raises `in_valid`. This exposes any sampling outside the frame boundary.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

    typedef enum logic [1:0] {
        FMT_MJ_0 = 2'd0,
        FMT_MJ_1 = 2'd1,
        FMT_MJ_2 = 2'd2,
        FMT_I2S  = 2'd3
    } fmt_e;

    // Formats whose word clock is inverted and whose MSB is delayed one slot
    function automatic logic fmt_delayed(fmt_e f);
        return (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/audio_ser_clkgen.sv
module audio_ser_clkgen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic fall_tick
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } st_t;

    st_t st_d, st_q;

    // fall_tick: the coming edge pulls sclk low and advances the slot
    assign fall_tick = (st_q.cnt == CNT_W'(DIV - 1));
    assign sclk      = st_q.sclk;

    always_comb begin
        st_d = st_q;
        if (fall_tick) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(HALF - 1)) begin
                st_d.sclk = 1'b1;
            end
        end
    end

    // Reset mid-period so the first event after reset is a falling one
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= CNT_W'(HALF);
            st_q.sclk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/audio_ser_framer.sv
module audio_ser_framer
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W   = 20,
    parameter int HALF_SLOTS = 32,
    parameter int SLOT_W     = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fall_tick,
    input  logic [1:0]          fmt_in,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic [SLOT_W-1:0]   slot_nx,
    output logic [1:0]          fmt_nx,
    output logic [SAMPLE_W-1:0] left_nx,
    output logic [SAMPLE_W-1:0] right_nx
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(2 * HALF_SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]   slot;
        fmt_e                fmt;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } st_t;

    st_t  st_d, st_q;
    logic start;

    always_comb begin
        st_d  = st_q;
        start = fall_tick && (st_q.slot == LAST);
        if (fall_tick) begin
            st_d.slot = start ? '0 : st_q.slot + 1'b1;
        end
        if (start) begin
            st_d.fmt = fmt_e'(fmt_in);
            if (in_valid) begin
                st_d.left  = in_left;
                st_d.right = in_right;
            end
        end
    end

    assign in_ready = start && !rst;
    assign slot_nx  = st_d.slot;
    assign fmt_nx   = st_d.fmt;
    assign left_nx  = st_d.left;
    assign right_nx = st_d.right;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.slot  <= LAST;
            st_q.fmt   <= FMT_MJ_0;
            st_q.left  <= '0;
            st_q.right <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/audio_ser_bitsel.sv
module audio_ser_bitsel
    import audio_ser_pkg::*;
#(
    parameter int SAMPLE_W   = 20,
    parameter int HALF_SLOTS = 32,
    parameter int SLOT_W     = 6
) (
    input  logic [SLOT_W-1:0]   slot,
    input  logic [1:0]          fmt,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    output logic                lrck_bit,
    output logic                data_bit
);
    logic                upper;
    logic                lead;
    logic [SAMPLE_W-1:0] word;
    int                  pos;
    int                  idx;

    // Bits past the half-frame are never reached, so a short half drops LSBs
    always_comb begin
        upper    = (int'(slot) >= HALF_SLOTS);
        pos      = int'(slot) - (upper ? HALF_SLOTS : 0);
        lead     = fmt_delayed(fmt_e'(fmt));
        word     = upper ? right : left;
        lrck_bit = lead ? upper : !upper;
        idx      = pos - (lead ? 1 : 0);
        data_bit = 1'b0;
        if (idx >= 0 && idx < SAMPLE_W) begin
            data_bit = word[SAMPLE_W-1-idx];
        end
    end

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
    parameter int SAMPLE_W   = 20,
    parameter int HALF_SLOTS = 32,
    parameter int DIV        = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_sel,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                in_ready,
    output logic                sclk,
    output logic                lrck,
    output logic                sdata
);
    localparam int SLOT_W = $clog2(2 * HALF_SLOTS);

    typedef struct packed {
        logic lrck;
        logic sdata;
    } out_t;

    out_t                out_d, out_q;
    logic                fall_tick;
    logic [SLOT_W-1:0]   slot_nx;
    logic [1:0]          fmt_nx;
    logic [SAMPLE_W-1:0] left_nx;
    logic [SAMPLE_W-1:0] right_nx;
    logic                lrck_bit;
    logic                data_bit;

    audio_ser_clkgen #(.DIV(DIV)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    audio_ser_framer #(
        .SAMPLE_W   (SAMPLE_W),
        .HALF_SLOTS (HALF_SLOTS),
        .SLOT_W     (SLOT_W)
    ) u_framer (
        .clk       (clk),
        .rst       (rst),
        .fall_tick (fall_tick),
        .fmt_in    (fmt_sel),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .in_ready  (in_ready),
        .slot_nx   (slot_nx),
        .fmt_nx    (fmt_nx),
        .left_nx   (left_nx),
        .right_nx  (right_nx)
    );

    audio_ser_bitsel #(
        .SAMPLE_W   (SAMPLE_W),
        .HALF_SLOTS (HALF_SLOTS),
        .SLOT_W     (SLOT_W)
    ) u_bitsel (
        .slot     (slot_nx),
        .fmt      (fmt_nx),
        .left     (left_nx),
        .right    (right_nx),
        .lrck_bit (lrck_bit),
        .data_bit (data_bit)
    );

    always_comb begin
        out_d = out_q;
        if (fall_tick) begin
            out_d.lrck  = lrck_bit;
            out_d.sdata = data_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign lrck  = out_q.lrck;
    assign sdata = out_q.sdata;

endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
    parameter int DIV = 8
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic lrck,
    input logic sdata,
    input logic in_ready
);
    localparam int HALF  = DIV / 2;
    localparam int RUN_W = $clog2(DIV) + 1;

    logic             sclk_prev_q;
    logic             armed_q;
    logic             seen_rst_q;
    logic [RUN_W-1:0] run_q;
    logic             chg;

    assign chg = (sclk != sclk_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= sclk;
            run_q       <= '0;
            armed_q     <= 1'b0;
        end else begin
            sclk_prev_q <= sclk;
            run_q       <= chg ? '0 : run_q + 1'b1;
            armed_q     <= armed_q | chg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rst_q <= 1'b1;
        end
    end

    // R1: each sclk level lasts DIV/2 system clocks
    always_ff @(posedge clk) begin
        if (!rst && armed_q && chg) begin
            assert_sclk_half_R1: assert (run_q == RUN_W'(HALF - 1))
                else $error("sclk level length wrong");
        end
    end

    // R2: all outputs quiet while reset is held
    always_ff @(posedge clk) begin
        if (rst && seen_rst_q) begin
            assert_quiet_in_reset_R2: assert (!sclk && !lrck && !sdata && !in_ready)
                else $error("output active during reset");
        end
    end

    assert_change_on_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sdata) || !$stable(lrck)) |-> !sclk)
        else $error("data or word clock moved while sclk high");

    assert_ready_single_R6: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready)
        else $error("in_ready held longer than one cycle");

endmodule

bind audio_ser_tx audio_ser_tx_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .lrck     (lrck),
    .sdata    (sdata),
    .in_ready (in_ready)
);

// File: tb/audio_ser_tx_test.sv
module audio_ser_tx_test;
    localparam int W   = 20;
    localparam int HS  = 32;
    localparam int DIV = 4;
    localparam int FS  = 2 * HS;
    localparam int NFR = 9;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   fmt_sel = 2'd0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_left = '0;
    logic [W-1:0] in_right = '0;
    logic         in_ready;
    logic         sclk;
    logic         lrck;
    logic         sdata;

    always #10 clk = ~clk;

    audio_ser_tx #(.SAMPLE_W(W), .HALF_SLOTS(HS), .DIV(DIV)) uut (
        .clk      (clk),
        .rst      (rst),
        .fmt_sel  (fmt_sel),
        .in_valid (in_valid),
        .in_left  (in_left),
        .in_right (in_right),
        .in_ready (in_ready),
        .sclk     (sclk),
        .lrck     (lrck),
        .sdata    (sdata)
    );

    typedef struct {
        logic [1:0]   fmt;
        logic [W-1:0] l;
        logic [W-1:0] r;
        bit           rep;
    } item_t;

    item_t exp_q[$];
    item_t held;
    int    n_run = 0;
    int    n_fail = 0;
    int    frames_done = 0;
    int    r1_bad = 0;
    int    r3_bad = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: offer a pair, wait for the frame-start handshake, push expectation
    task automatic send(input logic [1:0] f, input logic [W-1:0] l,
                        input logic [W-1:0] r, input bit v);
        fmt_sel  = f;
        in_valid = v;
        in_left  = l;
        in_right = r;
        while (!in_ready) @(negedge clk);
        held.fmt = f;
        if (v) begin
            held.l = l;
            held.r = r;
        end
        held.rep = !v;
        exp_q.push_back(held);
        @(negedge clk);
        check(in_ready == 1'b0, "R6", "in_ready one cycle", in_ready, 0);
        // R8: scramble format and data mid-frame; must not reach the output
        fmt_sel  = ~f;
        in_valid = 1'b1;
        in_left  = ~l;
        in_right = ~r;
        repeat (100) @(negedge clk);
    endtask

    // Monitor: receiver latching on sclk rising edges
    logic         lr_s [FS];
    logic         db_s [FS];
    logic         ps = 1'b0;
    logic         plr = 1'b0;
    logic         pda = 1'b0;
    bit           armed = 1'b0;
    int           gap = 0;
    int           slot = 0;

    task automatic judge();
        item_t        it;
        int           first;
        int           pad;
        int           lr_bad;
        logic [W-1:0] gw;
        logic [W-1:0] ew;
        string        tag;
        logic         explr;
        if (exp_q.size() == 0) return;
        it = exp_q.pop_front();
        frames_done++;
        first = (it.fmt == 2'd3) ? 1 : 0;
        tag = it.rep ? "R7" : ((it.fmt == 2'd3) ? "R5" : "R4");
        for (int h = 0; h < 2; h++) begin
            gw = '0;
            pad = 0;
            lr_bad = 0;
            for (int p = 0; p < HS; p++) begin
                explr = (it.fmt == 2'd3) ? (h == 1) : (h == 0);
                if (lr_s[h*HS+p] !== explr) lr_bad++;
                if (p >= first && p < first + W) gw = {gw[W-2:0], db_s[h*HS+p]};
                else if (db_s[h*HS+p] !== 1'b0) pad++;
            end
            ew = (h == 1) ? it.r : it.l;
            check(gw == ew, tag, (h == 1) ? "right word" : "left word", gw, ew);
            check(pad == 0, tag, "unused slots low", pad, 0);
            check(lr_bad == 0, "R8", "lrck polarity of latched format", lr_bad, 0);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            ps = 1'b0;
            gap = 0;
            slot = 0;
            armed = 1'b0;
            plr = lrck;
            pda = sdata;
        end else begin
            gap++;
            if ((sdata !== pda || lrck !== plr) && sclk !== 1'b0) r3_bad++;
            if (sclk && !ps) begin
                if (armed && gap != DIV) r1_bad++;
                armed = 1'b1;
                gap = 0;
                lr_s[slot] = lrck;
                db_s[slot] = sdata;
                slot++;
                if (slot == FS) begin
                    slot = 0;
                    judge();
                end
            end
            ps = sclk;
            plr = lrck;
            pda = sdata;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        held = '{fmt: 2'd0, l: '0, r: '0, rep: 1'b0};
        repeat (5) @(negedge clk);
        check(sclk == 1'b0, "R2", "sclk in reset", sclk, 0);
        check(lrck == 1'b0, "R2", "lrck in reset", lrck, 0);
        check(sdata == 1'b0, "R2", "sdata in reset", sdata, 0);
        check(in_ready == 1'b0, "R2", "in_ready in reset", in_ready, 0);
        rst = 1'b0;
        send(2'd0, 20'h12345, 20'hFEDCB, 1'b1);
        send(2'd1, 20'h80001, 20'h7FFFE, 1'b1);
        send(2'd3, 20'hABCDE, 20'h0F0F1, 1'b1);
        send(2'd3, 20'h11111, 20'h22222, 1'b0);
        send(2'd2, 20'h00001, 20'h80000, 1'b1);
        send(2'd0, 20'h33333, 20'h44444, 1'b0);
        send(2'd3, 20'hFFFFF, 20'h00000, 1'b1);
        send(2'd0, 20'h55555, 20'hAAAAA, 1'b1);
        send(2'd3, 20'hC3A5F, 20'h1E2D4, 1'b1);
        while (exp_q.size() != 0) @(negedge clk);
        check(frames_done == NFR, "R6", "frames delivered", frames_done, NFR);
        check(r1_bad == 0, "R1", "sclk periods off DIV", r1_bad, 0);
        check(r3_bad == 0, "R3", "changes while sclk high", r3_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule